// File: doc/BRIEF.md
# Feed-Protected Clock Multiplier Control

This block sits on a simple register bus and controls an external clock multiplier. Software writes an enable bit, a connect bit and a configuration word into pending registers. None of these writes reaches the multiplier directly. The pending values are copied to the active registers only when a two-write unlock pair arrives at the feed register: first 0xAA, then 0x55. Any other access inside the block's address window between the two writes cancels the unlock.

The active enable drives the multiplier's power-up input. The clock select output picks the multiplier output over the raw input clock. It is registered, and it is set only when the active enable, the active connect and the lock input are all high. A power-down input clears the active enable and connect. Leaving power-down does not bring them back.

Top module: `pll_feed_ctl`

## Requirements
- R1: After reset, `pll_en`, `clk_sel` and `pll_cfg` are zero, and every register reads back zero.
- R2: A write to CTRL (word index 0; bit 0 is enable, bit 1 is connect) or to CFG (word index 1; bits CFG_W-1:0) updates only the pending value. That value reads back at the same index, and the outputs do not change.
- R3: A write of 0xAA to FEED (word index 2), followed by a write of 0x55 to FEED on the next in-window access, copies the pending enable, connect and configuration to the active registers. The copy takes effect at the clock edge of the 0x55 write. Only bits 7:0 of a feed write are compared.
- R4: A feed write with any other value cancels the unlock. A 0x55 write with no 0xAA before it commits nothing. The sequence 0xAA, 0xAA, 0x55 commits nothing, because the second 0xAA cancels the first.
- R5: Any read or write inside the window (`bus_sel` high) between the two feed writes cancels the unlock. Bus activity while `bus_sel` is low does not cancel it.
- R6: `pll_en` equals the active enable. `clk_sel` goes high one cycle after the active enable, the active connect and `pll_lock` are all high, and it goes low one cycle after any of them falls.
- R7: An active connect without an active enable never sets `clk_sel`.
- R8: While `pwr_down` is high, the active enable and connect are cleared at each clock edge, and `clk_sel` is low from the next edge. This holds even when a 0x55 commit falls in the same cycle; the configuration part of that commit still applies. After `pwr_down` falls, the outputs stay off until a new unlock pair arrives.
- R9: STAT (word index 3) reads bit 0 = active enable, bit 1 = active connect, bit 2 = `pll_lock`, bit 3 = `clk_sel`, and all other bits zero. FEED reads as zero.
- R10: `pll_cfg` always equals the active configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access inside this block's window |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index: 0 CTRL, 1 CFG, 2 FEED, 3 STAT |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pll_lock | input | 1 | Lock status from the multiplier |
| pwr_down | input | 1 | Power-down request |
| pll_en | output | 1 | Multiplier enable |
| clk_sel | output | 1 | 1 = multiplier output is the system clock |
| pll_cfg | output | CFG_W | Active configuration word |

## Verification
A power-down request and the 0x55 commit write can land on the same clock edge. The bench raises `pwr_down` in exactly the cycle that carries the second feed write. It then expects the enable and connect to stay clear while the new configuration still appears. A cycle-level reference model in the bench predicts the outputs after every edge. A second collision also gets attention: an in-window read or a repeated 0xAA placed between the two feed writes must cancel the commit, while bus activity with `bus_sel` low must not.

// File: rtl/pll_feed_ctl.sv
module pll_feed_ctl #(
  parameter int          CFG_W = 24,
  parameter logic [7:0]  KEY_A = 8'hAA,
  parameter logic [7:0]  KEY_B = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             pll_lock,
  input  logic             pwr_down,
  output logic             pll_en,
  output logic             clk_sel,
  output logic [CFG_W-1:0] pll_cfg
);
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_CFG  = 2'd1;
  localparam logic [1:0] IDX_FEED = 2'd2;
  localparam logic [1:0] IDX_STAT = 2'd3;

  logic             pend_en, pend_con, act_en, act_con, armed, sel_q;
  logic [CFG_W-1:0] pend_cfg, act_cfg;
  logic             unused_hi;

  wire do_wr   = bus_sel & bus_wr;
  wire feed_wr = do_wr & (bus_addr == IDX_FEED);
  wire key_a   = feed_wr & (bus_wdata[7:0] == KEY_A);
  wire key_b   = feed_wr & (bus_wdata[7:0] == KEY_B);
  wire commit  = armed & key_b;

  assign unused_hi = ^bus_wdata[31:8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       armed <= 1'b0;
    else if (bus_sel) armed <= !armed && key_a;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_en  <= 1'b0;
      pend_con <= 1'b0;
      pend_cfg <= '0;
    end else if (do_wr) begin
      if (bus_addr == IDX_CTRL) begin
        pend_en  <= bus_wdata[0];
        pend_con <= bus_wdata[1];
      end
      if (bus_addr == IDX_CFG) pend_cfg <= bus_wdata[CFG_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_en  <= 1'b0;
      act_con <= 1'b0;
      act_cfg <= '0;
      sel_q   <= 1'b0;
    end else begin
      if (pwr_down) begin
        act_en  <= 1'b0;
        act_con <= 1'b0;
      end else if (commit) begin
        act_en  <= pend_en;
        act_con <= pend_con;
      end
      if (commit) act_cfg <= pend_cfg;
      sel_q <= act_en & act_con & pll_lock & ~pwr_down;
    end

  assign pll_en  = act_en;
  assign clk_sel = sel_q;
  assign pll_cfg = act_cfg;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IDX_CTRL: bus_rdata[1:0]       = {pend_con, pend_en};
      IDX_CFG:  bus_rdata[CFG_W-1:0] = pend_cfg;
      IDX_STAT: bus_rdata[3:0]       = {sel_q, pll_lock, act_con, act_en};
      default:  bus_rdata            = '0;
    endcase
  end

  // R8
  pd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (!pll_en && !clk_sel));

  // R6
  sel_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel) |-> $past(pll_en && pll_lock));

  // R7
  sel_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel |-> $past(pll_en));

  // R3
  en_rise_on_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> $past(bus_sel && bus_wr && bus_addr == IDX_FEED &&
                            bus_wdata[7:0] == KEY_B && !pwr_down));

  // R10
  cfg_change_on_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_cfg) |-> $past(bus_sel && bus_wr && bus_addr == IDX_FEED &&
                                bus_wdata[7:0] == KEY_B));
endmodule

// File: tb/pll_feed_ctl_bench.sv
`timescale 1ns/1ps
module pll_feed_ctl_bench;
  localparam int CFG_W = 24;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, pll_lock = 0, pwr_down = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic pll_en, clk_sel;
  logic [CFG_W-1:0] pll_cfg;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  pll_feed_ctl #(.CFG_W(CFG_W)) u_pll_feed_ctl (.*);

  always #2.5 clk = ~clk;

  // behavioural reference
  bit m_pen, m_pcon, m_aen, m_acon, m_sel, m_arm;
  int unsigned m_pcfg, m_acfg;
  always @(posedge clk) begin
    bit nsel, fire;
    if (!rst_n) begin
      {m_pen, m_pcon, m_aen, m_acon, m_sel, m_arm} = '0;
      m_pcfg = 0; m_acfg = 0;
    end else begin
      nsel = m_aen && m_acon && pll_lock && !pwr_down;
      fire = 0;
      if (bus_sel) begin
        if (bus_wr && bus_addr == 2 && m_arm && bus_wdata[7:0] == 8'h55) fire = 1;
        if (m_arm) m_arm = 0;
        else m_arm = bus_wr && bus_addr == 2 && bus_wdata[7:0] == 8'hAA;
      end
      if (fire) begin
        if (!pwr_down) begin m_aen = m_pen; m_acon = m_pcon; end
        m_acfg = m_pcfg;
      end
      if (pwr_down) begin m_aen = 0; m_acon = 0; end
      if (bus_sel && bus_wr && bus_addr == 0) begin m_pen = bus_wdata[0]; m_pcon = bus_wdata[1]; end
      if (bus_sel && bus_wr && bus_addr == 1) m_pcfg = bus_wdata & 32'hFF_FFFF;
      m_sel = nsel;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R6 pll_en vs model", {31'b0, pll_en}, {31'b0, m_aen});
    chk("R6 clk_sel vs model", {31'b0, clk_sel}, {31'b0, m_sel});
    chk("R10 pll_cfg vs model", {8'b0, pll_cfg}, m_acfg);
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
  endtask
  task automatic rd(logic [1:0] a, logic [31:0] exp, string req);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); bus_sel = 0; bus_wr = 0; end
  endtask
  task automatic feed();
    wr(2, 32'hAA); wr(2, 32'h55); idle(1);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    chk("R1 pll_en", {31'b0, pll_en}, 0);
    chk("R1 clk_sel", {31'b0, clk_sel}, 0);
    rd(3, 0, "R1 STAT"); rd(0, 0, "R1 CTRL"); rd(1, 0, "R1 CFG");
    // pending only
    wr(0, 3); wr(1, 32'hFF12_3456); idle(2);
    chk("R2 pll_en unchanged", {31'b0, pll_en}, 0);
    chk("R2 cfg unchanged", {8'b0, pll_cfg}, 0);
    rd(0, 3, "R2 CTRL readback"); rd(1, 32'h12_3456, "R2 CFG readback");
    // commit
    feed();
    chk("R3 pll_en after feed", {31'b0, pll_en}, 1);
    chk("R10 cfg after feed", {8'b0, pll_cfg}, 32'h12_3456);
    rd(3, 32'h3, "R9 STAT no lock");
    chk("R6 no lock no sel", {31'b0, clk_sel}, 0);
    @(negedge clk) pll_lock = 1; bus_sel = 0;
    idle(1);
    chk("R6 sel after lock", {31'b0, clk_sel}, 1);
    rd(3, 32'hF, "R9 STAT full");
    // intervening access
    wr(1, 32'hAB); wr(2, 32'hAA); rd(3, 32'hF, "R9 STAT mid feed"); wr(2, 32'h55); idle(1);
    chk("R5 read aborts", {8'b0, pll_cfg}, 32'h12_3456);
    wr(2, 32'hAA);
    @(negedge clk) bus_sel = 0; bus_wr = 1; bus_addr = 0; bus_wdata = 0;
    wr(2, 32'h55); idle(1);
    chk("R5 outside window ignored", {8'b0, pll_cfg}, 32'hAB);
    // wrong values
    wr(1, 32'h55);
    wr(2, 32'hAA); wr(2, 32'h56); idle(1);
    chk("R4 bad second key", {8'b0, pll_cfg}, 32'hAB);
    wr(2, 32'h55); idle(1);
    chk("R4 lone 0x55", {8'b0, pll_cfg}, 32'hAB);
    wr(2, 32'hAA); wr(2, 32'hAA); wr(2, 32'h55); idle(1);
    chk("R4 AA AA 55", {8'b0, pll_cfg}, 32'hAB);
    wr(2, 32'hFFFF_FFAA); wr(2, 32'h1234_5655); idle(1);
    chk("R3 upper feed bits ignored", {8'b0, pll_cfg}, 32'h55);
    // connect without enable
    wr(0, 2); feed(); idle(2);
    chk("R7 pll_en off", {31'b0, pll_en}, 0);
    chk("R7 no sel", {31'b0, clk_sel}, 0);
    rd(3, 32'h6, "R7 STAT con only");
    // power-down
    wr(0, 3); feed(); idle(2);
    chk("R8 running before pd", {31'b0, clk_sel}, 1);
    @(negedge clk) pwr_down = 1; bus_sel = 0;
    idle(1);
    chk("R8 en cleared", {31'b0, pll_en}, 0);
    chk("R8 sel cleared", {31'b0, clk_sel}, 0);
    @(negedge clk) pwr_down = 0;
    idle(3);
    chk("R8 no restore on wake", {31'b0, pll_en}, 0);
    rd(3, 32'h4, "R9 STAT after wake");
    // same-cycle commit and power-down
    wr(1, 32'h77); wr(2, 32'hAA); wr(2, 32'h55); pwr_down = 1;
    idle(1); pwr_down = 0;
    chk("R8 collision en stays off", {31'b0, pll_en}, 0);
    chk("R8 collision cfg applied", {8'b0, pll_cfg}, 32'h77);
    feed(); idle(1);
    chk("R8 fresh feed restores", {31'b0, clk_sel}, 1);
    rd(2, 0, "R9 FEED reads zero");
    @(negedge clk) pll_lock = 0; bus_sel = 0;
    idle(1);
    chk("R6 lock loss drops sel", {31'b0, clk_sel}, 0);
    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule